// File: doc/BRIEF.md
# Timebase Counter Pair

This block keeps two free-running time registers that run off a reference clock of nominally 25 MHz. The first is a sub-second counter. A 4-bit prescaler lets it move forward by 16 once every 16 reference cycles (640 ns at 25 MHz), so its four least significant bits are always zero. It returns to zero on reaching the reference frequency, which happens once per second. The second register counts the whole seconds elapsed since the last cold reset.

Software reads both values through a small word-addressed read port. Read data is registered and appears one clock after the read strobe. Both registers are read-only. A write strobe leaves the counters untouched and raises an error flag for one cycle. An active-low cold reset clears everything and restarts the timebase from zero.

Top module: `timebase_counter`

## Requirements
- R1: While `rstN` is low, both counters, `rdData` and `roErr` are zero.
- R2: The sub-second counter changes only on every 16th reference clock after reset release. Each change adds 16, so bits [3:0] always read zero. After n clock edges since release, its value is (floor(n/16)*16) mod REF_HZ.
- R3: The sub-second counter never reaches REF_HZ (default 25,000,000). The update that would reach REF_HZ sets it to zero instead.
- R4: The seconds counter increments by one in the same clock edge at which the sub-second counter wraps to zero, and at no other edge. After n edges since release, its value is floor(n/REF_HZ) mod 2^SEC_W.
- R5: The seconds counter is SEC_W bits wide (default 32). It wraps silently from all-ones to zero, and its value is zero-extended to 32 bits on reads.
- R6: Read map by word address `busAddr`: 0 returns the sub-second counter, 1 returns the seconds counter, and any other address returns zero. `rdData` is loaded on the edge that samples `busRd` high, so it is valid one clock after the strobe. It holds its value while `busRd` is low.
- R7: `busWr` does not change either counter at any address. `roErr` is high for exactly the one clock that follows each edge sampling `busWr` high, and low otherwise.
- R8: Asserting `rstN` low in the middle of a run clears both counters and the prescaler. Counting then restarts as from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (nominally 25 MHz) |
| rstN | input | 1 | Active-low asynchronous cold reset |
| busRd | input | 1 | Read strobe, one clock per read |
| busWr | input | 1 | Write strobe; writes are rejected |
| busAddr | input | ADDR_W (2) | Word address of the access |
| rdData | output | DATA_W (32) | Registered read data |
| roErr | output | 1 | One-cycle pulse flagging a rejected write |

## Verification
The properties assume that `rstN` is held low across at least one rising clock edge from time zero. They also assume that `busAddr`, `busRd` and `busWr` carry known values at every edge, and that REF_HZ is a whole multiple of 16. The stimulus drives every input at the falling edge, starts in reset, and keeps all bus signals at defined levels throughout. It shrinks REF_HZ to 320 and the seconds width to 4 bits, so the sub-second wrap and the seconds overflow both occur within a few thousand cycles. Reads cycle through all four addresses and are mixed with writes, so rejected writes overlap reads of the counters they might have disturbed.

// File: rtl/timebase_pkg.sv
package timebase_pkg;

  // which register the read port returns
  typedef enum logic [1:0] {
    SEL_CYC  = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_NONE = 2'd2
  } rdSel_e;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic   tick;    // prescaler wrapped: advance sub-second counter
    logic   wrap;    // this tick ends the current second
    logic   rdLoad;  // capture read data this edge
    logic   wrSeen;  // a write was attempted
    rdSel_e sel;     // decoded read source
  } tbStrobes_t;

endpackage

// File: rtl/timebase_ctrl.sv
module timebase_ctrl
  import timebase_pkg::*;
#(
  parameter int PRE_W  = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              atLimit,
  output tbStrobes_t        strobes
);

  localparam logic [ADDR_W-1:0] ADDR_CYC = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_SEC = ADDR_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic             preWrap;

  // prescaler: free-running count of reference cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preCnt + PRE_W'(1);
  end

  assign preWrap = &preCnt;

  rdSel_e selNext;
  always_comb begin
    if (busAddr == ADDR_CYC)      selNext = SEL_CYC;
    else if (busAddr == ADDR_SEC) selNext = SEL_SEC;
    else                          selNext = SEL_NONE;
  end

  always_comb begin
    strobes.tick   = preWrap;
    strobes.wrap   = preWrap & atLimit;
    strobes.rdLoad = busRd;
    strobes.wrSeen = busWr;
    strobes.sel    = selNext;
  end

endmodule

// File: rtl/timebase_dp.sv
module timebase_dp
  import timebase_pkg::*;
#(
  parameter int REF_HZ = 25_000_000,
  parameter int PRE_W  = 4,
  parameter int CNT_W  = 25,
  parameter int SEC_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbStrobes_t        strobes,
  output logic              atLimit,
  output logic [CNT_W-1:0]  cycVal,
  output logic [SEC_W-1:0]  secVal,
  output logic [DATA_W-1:0] rdData,
  output logic              roErr
);

  localparam int              STEP     = 2 ** PRE_W;
  localparam logic [CNT_W-1:0] STEP_V  = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] LAST_V  = CNT_W'(REF_HZ - STEP);

  assign atLimit = (cycVal == LAST_V);

  // sub-second counter, advances in coarse steps
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cycVal <= '0;
    else if (strobes.wrap) cycVal <= '0;
    else if (strobes.tick) cycVal <= cycVal + STEP_V;
  end

  // whole seconds since cold reset, wraps silently
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             secVal <= '0;
    else if (strobes.wrap) secVal <= secVal + SEC_W'(1);
  end

  logic [DATA_W-1:0] rdNext;
  always_comb begin
    unique case (strobes.sel)
      SEL_CYC: rdNext = DATA_W'(cycVal);
      SEL_SEC: rdNext = DATA_W'(secVal);
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
      roErr  <= 1'b0;
    end else begin
      if (strobes.rdLoad) rdData <= rdNext;
      roErr <= strobes.wrSeen;
    end
  end

endmodule

// File: rtl/timebase_counter.sv
module timebase_counter
  import timebase_pkg::*;
#(
  parameter int REF_HZ = 25_000_000,
  parameter int PRE_W  = 4,
  parameter int CNT_W  = 25,
  parameter int SEC_W  = 32,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              roErr
);

  tbStrobes_t       strobes;
  logic             atLimit;
  logic [CNT_W-1:0] cycVal;
  logic [SEC_W-1:0] secVal;

  timebase_ctrl #(
    .PRE_W (PRE_W),
    .ADDR_W(ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busRd  (busRd),
    .busWr  (busWr),
    .busAddr(busAddr),
    .atLimit(atLimit),
    .strobes(strobes)
  );

  timebase_dp #(
    .REF_HZ(REF_HZ),
    .PRE_W (PRE_W),
    .CNT_W (CNT_W),
    .SEC_W (SEC_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .atLimit(atLimit),
    .cycVal (cycVal),
    .secVal (secVal),
    .rdData (rdData),
    .roErr  (roErr)
  );

endmodule

// File: rtl/timebase_counter_chk.sv
module timebase_counter_chk #(
  parameter int REF_HZ = 25_000_000,
  parameter int PRE_W  = 4,
  parameter int CNT_W  = 25,
  parameter int SEC_W  = 32,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busRd,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              roErr,
  input logic [CNT_W-1:0]  cycVal,
  input logic [SEC_W-1:0]  secVal
);

  localparam int               STEP   = 2 ** PRE_W;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(STEP);
  localparam logic [CNT_W-1:0] LAST_V = CNT_W'(REF_HZ - STEP);
  localparam logic [CNT_W-1:0] LIM_V  = CNT_W'(REF_HZ);

  // R1: everything held at zero in reset
  always @(posedge clk) begin
    if (!rstN) begin
      a_r1_reset_zero: assert (cycVal == '0 && secVal == '0 && rdData == '0 && !roErr);
    end
  end

  // R2: coarse step only
  a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (!rstN)
    cycVal[PRE_W-1:0] == '0);

  a_r2_step_size: assert property (@(posedge clk) disable iff (!rstN)
    (cycVal != $past(cycVal)) |->
      ((cycVal == $past(cycVal) + STEP_V) || (cycVal == '0 && $past(cycVal) == LAST_V)));

  // R3: limit never reached
  a_r3_below_limit: assert property (@(posedge clk) disable iff (!rstN)
    cycVal < LIM_V);

  // R4: seconds move only together with the wrap
  a_r4_sec_on_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (secVal != $past(secVal)) |->
      ($past(cycVal) == LAST_V && cycVal == '0 && secVal == $past(secVal) + SEC_W'(1)));

  // R6: registered read of the sub-second counter, hold when idle
  a_r6_read_cyc: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == ADDR_W'(0)) |=> (rdData == DATA_W'($past(cycVal))));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(rdData));

  // R7: error pulse follows each write by one clock
  a_r7_err_on_write: assert property (@(posedge clk) disable iff (!rstN)
    busWr |=> roErr);

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busWr |=> !roErr);

endmodule

bind timebase_counter timebase_counter_chk #(
  .REF_HZ(REF_HZ),
  .PRE_W (PRE_W),
  .CNT_W (CNT_W),
  .SEC_W (SEC_W),
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .busRd  (busRd),
  .busWr  (busWr),
  .busAddr(busAddr),
  .rdData (rdData),
  .roErr  (roErr),
  .cycVal (cycVal),
  .secVal (secVal)
);

// File: tb/timebase_counter_bench.sv
module timebase_counter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int REF_HZ     = 320;
  localparam int SEC_W      = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] rdData;
  logic        roErr;

  timebase_counter #(
    .REF_HZ(REF_HZ),
    .PRE_W (4),
    .CNT_W (12),
    .SEC_W (SEC_W),
    .ADDR_W(2),
    .DATA_W(32)
  ) u_timebase_counter (
    .clk    (clk),
    .rstN   (rstN),
    .busRd  (busRd),
    .busWr  (busWr),
    .busAddr(busAddr),
    .rdData (rdData),
    .roErr  (roErr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  int    edges = 0;        // clock edges since reset release
  logic [31:0] expRd = '0, nextRd = '0;
  logic        expErr = 1'b0, nextErr = 1'b0;
  string       expTag = "R1", nextTag = "R1";

  // reference model: values after n edges since release
  function automatic logic [31:0] cycAt(int n);
    return 32'(((n / 16) * 16) % REF_HZ);
  endfunction

  function automatic logic [31:0] secAt(int n);
    return 32'((n / REF_HZ) % (1 << SEC_W));
  endfunction

  function automatic logic [31:0] readAt(int n, logic [1:0] a);
    if (a == 2'd0) return cycAt(n);
    if (a == 2'd1) return secAt(n);
    return 32'd0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at edge %0d", tag, act, exp, edges);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // one clock: advance model, compare, then drive next inputs
  task automatic stepCycle(logic r, logic rd, logic wr, logic [1:0] a, string rstTag);
    @(posedge clk);
    if (rstN) edges++;
    expRd  = nextRd;
    expErr = nextErr;
    expTag = nextTag;
    @(negedge clk);
    check(expTag, rdData, expRd);
    check(rstN ? "R7 roErr" : expTag, {31'd0, roErr}, {31'd0, expErr});
    rstN    = r;
    busRd   = r & rd;
    busWr   = r & wr;
    busAddr = a;
    if (!r) begin
      edges   = 0;
      nextRd  = '0;
      nextErr = 1'b0;
      nextTag = rstTag;
    end else begin
      nextRd  = (rd) ? readAt(edges, a) : expRd;
      nextErr = wr;
      if (!rd)             nextTag = "R6 hold";
      else if (a == 2'd0)  nextTag = (rstTag == "R8") ? "R8 R2 R3 R7" : "R2 R3 R6 R7";
      else if (a == 2'd1)  nextTag = (rstTag == "R8") ? "R8 R4 R5" : "R4 R5 R6 R7";
      else                 nextTag = "R6 unmapped";
    end
  endtask

  initial begin
    // R1: cold reset from time zero
    for (int i = 0; i < 3; i++) stepCycle(1'b0, 1'b0, 1'b0, 2'd0, "R1");
    // main run: long enough for the seconds counter to overflow (R5)
    for (int k = 0; k < 5400; k++)
      stepCycle(1'b1, (k % 5) != 4, (k % 7) == 3, 2'(k % 4), "R1");
    // R8: reset in the middle of a run
    for (int i = 0; i < 2; i++) stepCycle(1'b0, 1'b0, 1'b0, 2'd1, "R8");
    for (int k = 0; k < 700; k++)
      stepCycle(1'b1, (k % 3) != 2, (k % 11) == 5, 2'(k % 2), "R8");
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule